// File: doc/BRIEF.md
# External Interrupt Request Detector

This block watches eight active-low external request pins and one non-maskable request pin. Each maskable pin has its own two-bit sense code that selects one of four conditions: low level, falling edge, rising edge or either edge. When the selected condition appears, a sticky per-channel status flag is set. The request output for a channel is that flag gated by the channel's enable bit. The non-maskable pin has its own edge selection and raises a latched request that no enable bit can block. While that request is pending, the block drives its fixed vector number.

Software uses a small register bus with plain strobes to program the sense codes, the enables and the non-maskable edge selection. The same bus reads the status flags and clears them. A flag is cleared by software only if it was read as 1 before 0 is written to its bit. The flag is also cleared when the CPU acknowledges the channel. A transfer-engine acknowledge clears it too, unless that engine asks for the flag to be kept for the CPU. Every pin passes through a two-stage synchronizer. Edges are found by comparing consecutive synchronized samples, so each transition produces exactly one set event. No data stream passes through the block, so it has no valid/ready interface. Every pin is a plain control or status signal, and a register access completes in the cycle its strobe is high.

Top module: `xirq_detect`

## Requirements
- R1: After reset, every status flag, enable bit and request output is 0. Every sense code is 00 and the non-maskable edge select is 0 (falling), so `reg_rdata` reads 0 at every address.
- R2: With sense code 00 (low level), a channel's flag is set while its synchronized pin is low. The flag becomes visible on the third rising clock edge after the pin changes.
- R3: With sense code 01 (falling edge), a high-to-low pin transition sets the flag. A low-to-high transition does not set it.
- R4: With sense code 10 (rising edge), a low-to-high transition sets the flag. A high-to-low transition does not set it.
- R5: With sense code 11 (both edges), either transition sets the flag.
- R6: Status is at address 3, with bit n holding channel n. A status write of 0 to bit n clears the flag only if a status read since the previous status write returned bit n as 1. A write of 0 with no such read has no effect. Writing 1 never sets a flag.
- R7: In any edge mode, a `cpu_ack[n]` strobe clears flag n.
- R8: In low-level mode, a `cpu_ack[n]` strobe clears flag n only if the synchronized pin is high. Otherwise the flag stays set.
- R9: A `xfer_ack[n]` strobe clears flag n when `xfer_keep` is 0. When `xfer_keep` is 1, the flag is kept.
- R10: `irq_req[n]` equals flag n ANDed with enable bit n. The enable register is at address 2, with bit n holding channel n.
- R11: Bit 0 of address 4 selects the non-maskable edge (1 = rising, 0 = falling). The selected edge sets `nmi_req`, whatever the enables hold, and `nmi_req` stays set until `nmi_ack`. `nmi_vector` reads 7 while `nmi_req` is 1 and 0 otherwise.
- R12: If a set condition and a clear event land in the same cycle, the flag ends up set.
- R13: Sense codes for channels 3..0 are at address 0 and for channels 7..4 at address 1. Channel k's code {high,low} sits in bits [2(k mod 4)+1 : 2(k mod 4)], and a write reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (arms the status clear) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_irq | input | 8 | Asynchronous maskable request pins |
| pin_nmi | input | 1 | Asynchronous non-maskable request pin |
| cpu_ack | input | 8 | CPU acknowledge strobe per channel |
| xfer_ack | input | 8 | Transfer-engine acknowledge strobe per channel |
| xfer_keep | input | 1 | Keep-flag select for a transfer-engine acknowledge |
| nmi_ack | input | 1 | CPU acknowledge for the non-maskable request |
| irq_req | output | 8 | Maskable request per channel |
| nmi_req | output | 1 | Non-maskable request |
| nmi_vector | output | 8 | Vector number of the pending non-maskable request |

## Verification
Each sense code is driven with falling and rising pin transitions on its own channel. A transition that should set the flag does set it, and the opposite transition leaves it clear, so an edge-mode mix-up shows up. Low-level mode receives an acknowledge once while the pin is still low and once after the pin has returned high, which checks whether the pin level is consulted. The status-clear handshake is tried with a write that has no read before it and then with a read followed by a write, and transfer acknowledges are sent with both keep values. An acknowledge timed into the same cycle as a set event shows whether the set or the clear has priority.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int SENSE_W = 2;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic prev
);
  logic [STAGES-1:0] shr_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shr_q  <= {STAGES{IDLE}};
      prev_q <= IDLE;
    end else begin
      shr_q  <= {shr_q[STAGES-2:0], pin};
      prev_q <= shr_q[STAGES-1];
    end
  end

  assign lvl  = shr_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/xirq_flag.sv
module xirq_flag
  import xirq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  sense_e mode,
  input  logic   lvl,
  input  logic   prev,
  input  logic   cpu_ack,
  input  logic   xfer_ack,
  input  logic   xfer_keep,
  input  logic   sw_clr,
  output logic   flag
);
  logic fall, rise, set_ev, clr_ev, flag_q;

  assign fall = prev & ~lvl;
  assign rise = ~prev & lvl;

  always_comb begin
    unique case (mode)
      SENSE_LOW:  set_ev = ~lvl;
      SENSE_FALL: set_ev = fall;
      SENSE_RISE: set_ev = rise;
      default:    set_ev = fall | rise;
    endcase
  end

  assign clr_ev = sw_clr
                | (cpu_ack & ((mode != SENSE_LOW) | lvl))
                | (xfer_ack & ~xfer_keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_ev) flag_q <= 1'b1;
    else if (clr_ev) flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R8
  lvl_ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SENSE_LOW && cpu_ack && !lvl && flag_q) |=> flag_q);

  // R9
  keep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && xfer_keep && !cpu_ack && !sw_clr && flag_q) |=> flag_q);

  // R3 R4 R5
  edge_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && $past(mode) != SENSE_LOW) |-> ($past(lvl) != $past(prev)));
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW     = 8,
  parameter int AW     = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [AW-1:0]                  addr,
  input  logic                           wr,
  input  logic                           rd,
  input  logic [DW-1:0]                  wdata,
  output logic [DW-1:0]                  rdata,
  input  logic [NUM_CH-1:0]              flags,
  output logic [NUM_CH-1:0][SENSE_W-1:0] sense,
  output logic [NUM_CH-1:0]              en,
  output logic                           nmi_rise,
  output logic [NUM_CH-1:0]              sw_clr
);
  localparam int CPW    = DW / SENSE_W;
  localparam int SWORDS = (NUM_CH + CPW - 1) / CPW;
  localparam logic [AW-1:0] EN_A = AW'(SWORDS);
  localparam logic [AW-1:0] ST_A = AW'(SWORDS + 1);
  localparam logic [AW-1:0] CT_A = AW'(SWORDS + 2);

  logic [NUM_CH-1:0][SENSE_W-1:0] sense_q;
  logic [NUM_CH-1:0]              en_q, arm_q;
  logic                           nrise_q;
  logic                           st_wr, st_rd;

  assign st_wr = wr && addr == ST_A;
  assign st_rd = rd && addr == ST_A;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      en_q    <= '0;
      nrise_q <= 1'b0;
    end else if (wr) begin
      for (int c = 0; c < NUM_CH; c++)
        if (addr == AW'(c / CPW))
          sense_q[c] <= wdata[SENSE_W*(c%CPW) +: SENSE_W];
      if (addr == EN_A) en_q    <= wdata[NUM_CH-1:0];
      if (addr == CT_A) nrise_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     arm_q <= '0;
    else if (st_wr) arm_q <= '0;
    else if (st_rd) arm_q <= arm_q | flags;
  end

  assign sw_clr = st_wr ? (arm_q & ~wdata[NUM_CH-1:0]) : '0;

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr == AW'(c / CPW))
        rdata[SENSE_W*(c%CPW) +: SENSE_W] = sense_q[c];
    if (addr == EN_A) rdata[NUM_CH-1:0] = en_q;
    if (addr == ST_A) rdata[NUM_CH-1:0] = flags;
    if (addr == CT_A) rdata[0]          = nrise_q;
  end

  assign sense    = sense_q;
  assign en       = en_q;
  assign nmi_rise = nrise_q;

  // R6
  arm_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_q & ~$past(arm_q) & ~$past(flags)) == '0));
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DW          = 8,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2,
  parameter int NMI_VEC     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NUM_CH-1:0] pin_irq,
  input  logic              pin_nmi,
  input  logic [NUM_CH-1:0] cpu_ack,
  input  logic [NUM_CH-1:0] xfer_ack,
  input  logic              xfer_keep,
  input  logic              nmi_ack,
  output logic [NUM_CH-1:0] irq_req,
  output logic              nmi_req,
  output logic [7:0]        nmi_vector
);
  logic [NUM_CH-1:0][SENSE_W-1:0] sense;
  logic [NUM_CH-1:0]              en, flags, sw_clr, lvl, prev;
  logic                           nmi_rise, n_lvl, n_prev, n_edge, nmi_q;

  xirq_regs #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .rdata(reg_rdata), .flags(flags), .sense(sense),
    .en(en), .nmi_rise(nmi_rise), .sw_clr(sw_clr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    xirq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pin_irq[i]), .lvl(lvl[i]), .prev(prev[i])
    );
    xirq_flag u_flag (
      .clk(clk), .rst_n(rst_n), .mode(sense_e'(sense[i])), .lvl(lvl[i]),
      .prev(prev[i]), .cpu_ack(cpu_ack[i]), .xfer_ack(xfer_ack[i]),
      .xfer_keep(xfer_keep), .sw_clr(sw_clr[i]), .flag(flags[i])
    );
  end

  assign irq_req = flags & en;

  xirq_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_nmi_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_nmi), .lvl(n_lvl), .prev(n_prev)
  );

  assign n_edge = nmi_rise ? (~n_prev & n_lvl) : (n_prev & ~n_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       nmi_q <= 1'b0;
    else if (n_edge)  nmi_q <= 1'b1;
    else if (nmi_ack) nmi_q <= 1'b0;
  end

  assign nmi_req    = nmi_q;
  assign nmi_vector = nmi_q ? 8'(NMI_VEC) : 8'd0;

  // R11
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_q && !nmi_ack) |=> nmi_q);

  // R10
  req_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |-> (|(flags & irq_req)));
endmodule

// File: tb/tb_xirq_detect.sv
module tb_xirq_detect;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] pin_irq = 8'hFF;
  logic       pin_nmi = 1'b1;
  logic [7:0] cpu_ack = '0, xfer_ack = '0;
  logic       xfer_keep = 1'b0, nmi_ack = 1'b0;
  logic [7:0] irq_req, nmi_vector;
  logic       nmi_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xirq_detect dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic cpu_pulse(input int ch);
    cpu_ack[ch] = 1'b1; @(negedge clk); cpu_ack[ch] = 1'b0;
  endtask

  task automatic xfer_pulse(input int ch, input logic keep);
    xfer_ack[ch] = 1'b1; xfer_keep = keep; @(negedge clk);
    xfer_ack[ch] = 1'b0; xfer_keep = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rd_reg(3'(a), d);
      chk(d == 8'h00, "R1 reg", d, 0);
    end
    chk(irq_req == 0 && nmi_req == 0 && nmi_vector == 0, "R1 outputs",
        {irq_req, nmi_req}, 0);
  endtask

  task automatic t_level();
    wr_reg(3'd2, 8'hFF);
    pin_irq[0] = 1'b0; wait_n(2);
    chk(irq_req[0] == 1'b0, "R2 early", irq_req[0], 0);
    wait_n(1);
    chk(irq_req[0] == 1'b1, "R2 set on third edge", irq_req[0], 1);
    cpu_pulse(0);
    chk(irq_req[0] == 1'b1, "R8 ack while low", irq_req[0], 1);
    pin_irq[0] = 1'b1; wait_n(4);
    chk(irq_req[0] == 1'b1, "R2 sticky", irq_req[0], 1);
    cpu_pulse(0);
    chk(irq_req[0] == 1'b0, "R8 ack while high", irq_req[0], 0);
  endtask

  task automatic t_fall();
    wr_reg(3'd0, 8'h04);
    pin_irq[1] = 1'b0; wait_n(4);
    chk(irq_req[1] == 1'b1, "R3 falling sets", irq_req[1], 1);
    cpu_pulse(1);
    chk(irq_req[1] == 1'b0, "R7 ack clears edge", irq_req[1], 0);
    pin_irq[1] = 1'b1; wait_n(4);
    chk(irq_req[1] == 1'b0, "R3 rising ignored", irq_req[1], 0);
  endtask

  task automatic t_rise_swclr();
    logic [7:0] d;
    wr_reg(3'd1, 8'h08);
    pin_irq[5] = 1'b0; wait_n(4);
    chk(irq_req[5] == 1'b0, "R4 falling ignored", irq_req[5], 0);
    pin_irq[5] = 1'b1; wait_n(4);
    chk(irq_req[5] == 1'b1, "R4 rising sets", irq_req[5], 1);
    wr_reg(3'd3, 8'h00);
    chk(irq_req[5] == 1'b1, "R6 write without read", irq_req[5], 1);
    rd_reg(3'd3, d);
    chk(d == 8'h20, "R6 status read", d, 8'h20);
    wr_reg(3'd3, 8'h00);
    chk(irq_req[5] == 1'b0, "R6 read then write 0", irq_req[5], 0);
    wr_reg(3'd3, 8'hFF);
    rd_reg(3'd3, d);
    chk(d == 8'h00, "R6 write 1 no set", d, 0);
  endtask

  task automatic t_both_xfer();
    wr_reg(3'd1, 8'hC8);
    pin_irq[7] = 1'b0; wait_n(4);
    chk(irq_req[7] == 1'b1, "R5 falling sets", irq_req[7], 1);
    xfer_pulse(7, 1'b1);
    chk(irq_req[7] == 1'b1, "R9 keep=1 holds", irq_req[7], 1);
    xfer_pulse(7, 1'b0);
    chk(irq_req[7] == 1'b0, "R9 keep=0 clears", irq_req[7], 0);
    pin_irq[7] = 1'b1; wait_n(4);
    chk(irq_req[7] == 1'b1, "R5 rising sets", irq_req[7], 1);
    cpu_pulse(7);
    chk(irq_req[7] == 1'b0, "R7 ack clears both", irq_req[7], 0);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    pin_irq[7] = 1'b0; wait_n(4);
    wr_reg(3'd2, 8'h00);
    chk(irq_req == 8'h00, "R10 masked", irq_req, 0);
    rd_reg(3'd3, d);
    chk(d == 8'h80, "R10 flag kept", d, 8'h80);
    wr_reg(3'd2, 8'h80);
    chk(irq_req == 8'h80, "R10 unmasked", irq_req, 8'h80);
    cpu_pulse(7);
    wr_reg(3'd2, 8'hFF);
  endtask

  task automatic t_setwins();
    pin_irq[1] = 1'b0; wait_n(2);
    cpu_ack[1] = 1'b1; @(negedge clk); cpu_ack[1] = 1'b0;
    chk(irq_req[1] == 1'b1, "R12 set wins", irq_req[1], 1);
    cpu_pulse(1);
    chk(irq_req[1] == 1'b0, "R12 later clear", irq_req[1], 0);
    pin_irq[1] = 1'b1; wait_n(4);
  endtask

  task automatic t_sense_map();
    logic [7:0] d;
    rd_reg(3'd0, d);
    chk(d == 8'h04, "R13 low word", d, 8'h04);
    rd_reg(3'd1, d);
    chk(d == 8'hC8, "R13 high word", d, 8'hC8);
  endtask

  task automatic t_nmi();
    wr_reg(3'd2, 8'h00);
    pin_nmi = 1'b0; wait_n(4);
    chk(nmi_req == 1'b1 && nmi_vector == 8'd7, "R11 falling", nmi_vector, 7);
    wait_n(3);
    chk(nmi_req == 1'b1, "R11 held", nmi_req, 1);
    nmi_ack = 1'b1; @(negedge clk); nmi_ack = 1'b0;
    chk(nmi_req == 1'b0 && nmi_vector == 8'd0, "R11 ack", nmi_vector, 0);
    pin_nmi = 1'b1; wait_n(4);
    chk(nmi_req == 1'b0, "R11 rising ignored", nmi_req, 0);
    wr_reg(3'd4, 8'h01);
    pin_nmi = 1'b0; wait_n(4);
    chk(nmi_req == 1'b0, "R11 falling ignored", nmi_req, 0);
    pin_nmi = 1'b1; wait_n(4);
    chk(nmi_req == 1'b1, "R11 rising", nmi_req, 1);
    nmi_ack = 1'b1; @(negedge clk); nmi_ack = 1'b0;
  endtask

  initial begin
    wait_n(3); rst_n = 1'b1; wait_n(2);
    t_reset();
    t_level();
    t_fall();
    t_rise_swclr();
    t_both_xfer();
    t_enable();
    t_setwins();
    t_sense_map();
    t_nmi();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule